// File: doc/BRIEF.md
# ADC Host Bus Interface Controller

This block sits between a host processor bus and the core of a sampling analog-to-digital converter. The host drives four strobes: an active-low chip select, an active-low sample/hold, an active-low read and an active-high output enable. The block turns them into conversion requests for the core and reports each finished conversion through an end-of-conversion level and an active-low interrupt. It keeps the 12-bit result in a register and decides when that result may be driven onto a shared three-state data bus.

The bus has two modes of use. In interrupt mode the host waits for the interrupt and then issues a read. The falling edge of that read returns the interrupt to its idle level, and the bus is enabled only while the read is active. In high-speed mode no interrupt is raised. The latest result stays on the bus whenever output enable is high, so the host can fetch it with no interrupt-to-read delay.

Every strobe crosses into the block clock domain through a two-flop synchroniser before edge detection. The converter core shares the block clock and returns a one-cycle completion pulse together with its data word.

Top module: `adc_hostif`

## Requirements
- R1: While reset is asserted and just after it is released, eoc is 1, int_n is 1, overrun is 0, conv_start is 0 and data_out is 0.
- R2: A falling edge on sh_n while the synchronised cs_n is 0 starts a conversion. Three clock edges after the input changes, conv_start is 1 for exactly one cycle and eoc is 0.
- R3: A falling edge on sh_n while cs_n is 1 has no effect: no conv_start pulse, and eoc stays 1.
- R4: When conv_done is 1 during a conversion, the next edge latches conv_data onto data_out, sets eoc to 1 and, in interrupt mode (mode_fast = 0), drives int_n to 0.
- R5: A falling edge on rd_n while cs_n is 0 returns int_n to 1 three edges after the input changes. A falling edge on rd_n while cs_n is 1 leaves int_n unchanged.
- R6: In interrupt mode, data_oe is 1 exactly when oe is 1, cs_n is 0 and rd_n is 0, two edges after the inputs settle. Otherwise data_oe is 0.
- R7: In high-speed mode (mode_fast = 1), data_oe follows oe alone, data_out holds the latest result, and int_n stays 1 when a conversion completes.
- R8: A gated sh_n falling edge during a conversion neither restarts it nor pulses conv_start. It sets the sticky overrun flag, and a gated rd_n falling edge clears that flag.
- R9: conv_done while no conversion is in progress is ignored: data_out, eoc and int_n do not change.
- R10: eoc stays 0 from the start of a conversion until the cycle after conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_fast | input | 1 | 1 selects high-speed mode, 0 selects interrupt mode |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sh_n | input | 1 | Sample/hold strobe; a falling edge requests a conversion |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| oe | input | 1 | Output enable, active high, asynchronous |
| conv_start | output | 1 | One-cycle request to the converter core |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_data | input | 12 | Result word from the core, valid with conv_done |
| eoc | output | 1 | End of conversion, high when no conversion is running |
| int_n | output | 1 | Interrupt, active low |
| overrun | output | 1 | Sticky flag for a sample request lost during a conversion |
| data_out | output | 12 | Latched conversion result |
| data_oe | output | 1 | Drive enable for the three-state data bus |

## Verification
Strobe-triggered actions (conversion start, interrupt clear, overrun set and clear) are due on the third rising edge after a pin changes: two synchroniser flops and one state register. The bus enable is due on the second edge, because it is formed combinationally from the synchronised levels. Results triggered by conv_done are due on the first edge after the pulse. The bench drives pins on falling edges and samples on the falling edge after the rising edge at which each result is due. It also samples one cycle earlier where it must show that a result has not yet appeared, such as eoc still low in the cycle before completion.

// File: rtl/adc_hostif_pkg.sv
package adc_hostif_pkg;

    localparam int DATA_W      = 12;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_STROBES = 4;

    // bit positions of the strobes inside the synchroniser vector
    localparam int IDX_CS = 0;
    localparam int IDX_SH = 1;
    localparam int IDX_RD = 2;
    localparam int IDX_OE = 3;

    // idle level of each strobe: selects and strobes high, output enable low
    localparam logic [NUM_STROBES-1:0] STROBE_IDLE = 4'b0111;

    typedef struct packed {
        logic oe;
        logic rd_n;
        logic sh_n;
        logic cs_n;
    } strobe_t;

    typedef enum logic {
        CONV_IDLE = 1'b0,
        CONV_BUSY = 1'b1
    } conv_state_t;

    typedef struct packed {
        logic eoc;
        logic int_n;
        logic overrun;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{eoc: 1'b1, int_n: 1'b1, overrun: 1'b0};

    function automatic logic bus_enable(input logic fast, input strobe_t lvl);
        return lvl.oe & (fast | (~lvl.cs_n & ~lvl.rd_n));
    endfunction

endpackage

// File: rtl/adc_hostif_sync.sv
module adc_hostif_sync #(
    parameter int            N       = 4,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] level,
    output logic [N-1:0] fall
);

    localparam int CHAIN_W = STAGES + 1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CHAIN_W-1:0] chain;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= {CHAIN_W{RST_VAL[i]}};
            end else begin
                chain <= {chain[CHAIN_W-2:0], din[i]};
            end
        end

        // last synchroniser stage is the level; one more flop gives the edge
        assign level[i] = chain[STAGES-1];
        assign fall[i]  = chain[STAGES] & ~chain[STAGES-1];
    end

endmodule

// File: rtl/adc_hostif_seq.sv
module adc_hostif_seq
    import adc_hostif_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fast,
    input  logic          sh_go,
    input  logic          rd_go,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    output logic          conv_start,
    output flags_t        flags,
    output logic [DW-1:0] result
);

    conv_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CONV_IDLE;
            conv_start <= 1'b0;
            flags      <= FLAGS_RESET;
            result     <= '0;
        end else begin
            conv_start <= 1'b0;
            unique case (state_q)
                CONV_IDLE: begin
                    if (sh_go) begin
                        state_q    <= CONV_BUSY;
                        conv_start <= 1'b1;
                        flags.eoc  <= 1'b0;
                    end
                end
                CONV_BUSY: begin
                    if (conv_done) begin
                        state_q   <= CONV_IDLE;
                        result    <= conv_data;
                        flags.eoc <= 1'b1;
                        if (!fast) begin
                            flags.int_n <= 1'b0;
                        end
                    end
                end
                default: state_q <= CONV_IDLE;
            endcase

            // lost sample request; a read in the same cycle wins
            if (sh_go && state_q == CONV_BUSY) begin
                flags.overrun <= 1'b1;
            end
            if (rd_go) begin
                flags.int_n   <= 1'b1;
                flags.overrun <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_hostif_bus.sv
module adc_hostif_bus
    import adc_hostif_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          fast,
    input  strobe_t       lvl,
    input  logic [DW-1:0] result,
    output logic [DW-1:0] data_out,
    output logic          data_oe
);

    assign data_oe  = bus_enable(fast, lvl);
    assign data_out = result;

endmodule

// File: rtl/adc_hostif.sv
module adc_hostif
    import adc_hostif_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_fast,
    input  logic          cs_n,
    input  logic          sh_n,
    input  logic          rd_n,
    input  logic          oe,
    output logic          conv_start,
    input  logic          conv_done,
    input  logic [DW-1:0] conv_data,
    output logic          eoc,
    output logic          int_n,
    output logic          overrun,
    output logic [DW-1:0] data_out,
    output logic          data_oe
);

    strobe_t                raw;
    strobe_t                lvl;
    logic [NUM_STROBES-1:0] lvl_vec;
    logic [NUM_STROBES-1:0] fall_vec;
    logic                   sh_go;
    logic                   rd_go;
    flags_t                 flags;
    logic [DW-1:0]          result;

    assign raw = '{oe: oe, rd_n: rd_n, sh_n: sh_n, cs_n: cs_n};

    adc_hostif_sync #(
        .N       (NUM_STROBES),
        .STAGES  (STAGES),
        .RST_VAL (STROBE_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (raw),
        .level (lvl_vec),
        .fall  (fall_vec)
    );

    assign lvl   = strobe_t'(lvl_vec);
    assign sh_go = fall_vec[IDX_SH] & ~lvl.cs_n;
    assign rd_go = fall_vec[IDX_RD] & ~lvl.cs_n;

    adc_hostif_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .fast       (mode_fast),
        .sh_go      (sh_go),
        .rd_go      (rd_go),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .conv_start (conv_start),
        .flags      (flags),
        .result     (result)
    );

    adc_hostif_bus #(.DW(DW)) u_bus (
        .fast     (mode_fast),
        .lvl      (lvl),
        .result   (result),
        .data_out (data_out),
        .data_oe  (data_oe)
    );

    assign eoc     = flags.eoc;
    assign int_n   = flags.int_n;
    assign overrun = flags.overrun;

endmodule

// File: rtl/adc_hostif_chk.sv
module adc_hostif_chk (
    input logic clk,
    input logic rst,
    input logic mode_fast,
    input logic conv_start,
    input logic conv_done,
    input logic eoc,
    input logic int_n,
    input logic overrun
);

    // R2: a start request coincides with eoc low
    a_r2_start_drops_eoc: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !eoc);

    // R2: start request lasts one cycle
    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    // R4: the interrupt is raised only together with end of conversion
    a_r4_int_with_eoc: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> $rose(eoc));

    // R7: no interrupt in high-speed mode
    a_r7_fast_no_int: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> !$past(mode_fast));

    // R10: eoc returns high only after a completion pulse
    a_r10_eoc_needs_done: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> $past(conv_done));

    // R8: overrun is raised only while a conversion runs
    a_r8_overrun_in_conv: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> !$past(eoc));

endmodule

bind adc_hostif adc_hostif_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_fast  (mode_fast),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .eoc        (eoc),
    .int_n      (int_n),
    .overrun    (overrun)
);

// File: tb/adc_hostif_tb_top.sv
module adc_hostif_tb_top;

    localparam int DW  = 12;
    localparam int LAT = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_fast = 1'b0;
    logic          cs_n = 1'b0;
    logic          sh_n = 1'b1;
    logic          rd_n = 1'b1;
    logic          oe   = 1'b0;
    logic          conv_start;
    logic          core_done = 1'b0;
    logic [DW-1:0] core_data = '0;
    logic          inj_done  = 1'b0;
    logic          conv_done;
    logic [DW-1:0] conv_data;
    logic          eoc;
    logic          int_n;
    logic          overrun;
    logic [DW-1:0] data_out;
    logic          data_oe;

    int            checks = 0;
    int            errors = 0;
    int            starts = 0;
    int            cnt    = 0;
    logic [DW-1:0] next_word = '0;
    bit            finished  = 1'b0;

    always #5 clk = ~clk;

    assign conv_done = core_done | inj_done;
    assign conv_data = inj_done ? {DW{1'b1}} : core_data;

    adc_hostif dut_i (
        .clk        (clk),
        .rst        (rst),
        .mode_fast  (mode_fast),
        .cs_n       (cs_n),
        .sh_n       (sh_n),
        .rd_n       (rd_n),
        .oe         (oe),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .eoc        (eoc),
        .int_n      (int_n),
        .overrun    (overrun),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    // converter core model: fixed latency, then a one-cycle done pulse
    always @(posedge clk) begin
        core_done <= 1'b0;
        if (rst) begin
            cnt <= 0;
        end else if (conv_start) begin
            cnt <= LAT;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                core_done <= 1'b1;
                core_data <= next_word;
            end
        end
        if (!rst && conv_start) starts <= starts + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full conversion: pins change at a falling edge, eoc due 13 edges later
    task automatic do_conv(input logic [DW-1:0] word);
        int s0;
        s0 = starts;
        next_word = word;
        @(negedge clk);
        sh_n = 1'b0;
        wait_n(3);
        chk("R2 conv_start", 32'(conv_start), 32'd1);
        chk("R2 eoc low", 32'(eoc), 32'd0);
        sh_n = 1'b1;
        wait_n(9);
        chk("R10 eoc still low", 32'(eoc), 32'd0);
        wait_n(1);
        chk("R4 eoc high", 32'(eoc), 32'd1);
        chk("R4 int_n", 32'(int_n), mode_fast ? 32'd1 : 32'd0);
        chk("R4 data latched", 32'(data_out), 32'(word));
        chk("R2 one start", 32'(starts - s0), 32'd1);
    endtask

    task automatic do_read(input logic [DW-1:0] word);
        @(negedge clk);
        rd_n = 1'b0;
        oe   = 1'b1;
        wait_n(2);
        chk("R6 bus on during read", 32'(data_oe), 32'd1);
        chk("R6 bus data", 32'(data_out), 32'(word));
        wait_n(1);
        chk("R5 int cleared by read", 32'(int_n), 32'd1);
        rd_n = 1'b1;
        oe   = 1'b0;
        wait_n(3);
    endtask

    initial begin
        logic [DW-1:0] w;
        wait_n(4);
        chk("R1 eoc", 32'(eoc), 32'd1);
        chk("R1 int_n", 32'(int_n), 32'd1);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 conv_start", 32'(conv_start), 32'd0);
        chk("R1 data", 32'(data_out), 32'd0);
        rst = 1'b0;
        wait_n(4);
        chk("R1 eoc after release", 32'(eoc), 32'd1);
        chk("R1 int_n after release", 32'(int_n), 32'd1);

        // interrupt mode, several data words
        for (int i = 0; i < 6; i++) begin
            w = DW'((i * 695 + 19) % 4096);
            do_conv(w);
            chk("R6 bus off before read", 32'(data_oe), 32'd0);
            do_read(w);
        end

        // R3: sample strobe with chip select high
        begin
            int s0;
            s0 = starts;
            @(negedge clk);
            cs_n = 1'b1;
            sh_n = 1'b0;
            wait_n(5);
            chk("R3 no start", 32'(starts - s0), 32'd0);
            chk("R3 eoc stays", 32'(eoc), 32'd1);
            sh_n = 1'b1;
            wait_n(3);
            cs_n = 1'b0;
            wait_n(3);
        end

        // R5: read with chip select high does not clear the interrupt
        w = 12'h5A3;
        do_conv(w);
        @(negedge clk);
        cs_n = 1'b1;
        rd_n = 1'b0;
        wait_n(5);
        chk("R5 ungated read ignored", 32'(int_n), 32'd0);
        rd_n = 1'b1;
        wait_n(3);
        cs_n = 1'b0;
        wait_n(3);
        do_read(w);

        // R8: second sample request during a conversion
        begin
            int s0;
            s0 = starts;
            next_word = 12'h3C7;
            @(negedge clk);
            sh_n = 1'b0;
            wait_n(3);
            sh_n = 1'b1;
            wait_n(2);
            sh_n = 1'b0;
            wait_n(3);
            chk("R8 overrun set", 32'(overrun), 32'd1);
            chk("R8 still converting", 32'(eoc), 32'd0);
            sh_n = 1'b1;
            wait_n(5);
            chk("R8 eoc after first conv", 32'(eoc), 32'd1);
            chk("R8 data of first conv", 32'(data_out), 32'h3C7);
            chk("R8 single start", 32'(starts - s0), 32'd1);
            wait_n(LAT + 4);
            chk("R8 no restart", 32'(starts - s0), 32'd1);
            chk("R8 overrun sticky", 32'(overrun), 32'd1);
            do_read(12'h3C7);
            chk("R8 overrun cleared", 32'(overrun), 32'd0);
        end

        // R9: completion pulse while idle
        @(negedge clk);
        inj_done = 1'b1;
        @(negedge clk);
        inj_done = 1'b0;
        wait_n(2);
        chk("R9 data kept", 32'(data_out), 32'h3C7);
        chk("R9 eoc kept", 32'(eoc), 32'd1);
        chk("R9 int_n kept", 32'(int_n), 32'd1);

        // R7: high-speed mode
        mode_fast = 1'b1;
        for (int i = 0; i < 4; i++) begin
            w = DW'((i * 1187 + 301) % 4096);
            do_conv(w);
            @(negedge clk);
            cs_n = 1'b1;
            oe   = 1'b1;
            wait_n(2);
            chk("R7 bus on with oe only", 32'(data_oe), 32'd1);
            chk("R7 bus data", 32'(data_out), 32'(w));
            chk("R7 no interrupt", 32'(int_n), 32'd1);
            oe   = 1'b0;
            cs_n = 1'b0;
            wait_n(3);
        end

        // R6 / R7: bus enable over all strobe combinations in both modes
        for (int m = 0; m < 2; m++) begin
            mode_fast = m[0];
            for (int c = 0; c < 8; c++) begin
                logic exp_oe;
                @(negedge clk);
                cs_n = c[0];
                rd_n = c[1];
                oe   = c[2];
                exp_oe = c[2] & (m[0] | (~c[0] & ~c[1]));
                wait_n(2);
                chk(m[0] ? "R7 bus enable sweep" : "R6 bus enable sweep",
                    32'(data_oe), 32'(exp_oe));
                cs_n = 1'b0;
                rd_n = 1'b1;
                oe   = 1'b0;
                wait_n(3);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule